// File: doc/BRIEF.md
# Fixed-Point to Signed Integer Rounder

This unit turns a sign-and-magnitude fixed-point number into a saturated, signed two's-complement integer. The magnitude is an unsigned word whose lowest bits form the fraction. A separate sign flag says whether the value is negative. A small mode code picks one of five rounding directions. Along with the integer, the unit reports two per-operation flags. One says the value could not be represented. The other says precision was lost. It is meant to sit at the end of a float-to-integer conversion path, after the exponent has been used to align the mantissa.

Rounding works by adding a mode- and sign-dependent constant to the fraction field and then dropping the fraction. An exact half in nearest-even mode is forced to an even result. If the rounded value falls outside the signed output range, the output saturates toward the sign of the input and the invalid flag is raised. The result and both flags can be registered (one cycle of latency, the default) or passed straight through.

Top module: `fx_round_int`

## Requirements
- R1: The low 7 bits of `mag_i` are fraction bits. With `mode_i` = 3'b001 (toward zero) the fraction is discarded and the integer part is returned unchanged.
- R2: With `mode_i` = 3'b000 (nearest, ties to even), a fraction above 0x40 rounds the magnitude up and a fraction below 0x40 rounds it down. A fraction of exactly 0x40 rounds to whichever neighbour is even.
- R3: With `mode_i` = 3'b100 (nearest, ties away), a fraction of 0x40 or more rounds the magnitude up and anything less rounds it down, for either sign.
- R4: With `mode_i` = 3'b011 (toward plus infinity), a non-zero fraction raises the magnitude of a positive value by one and leaves the magnitude of a negative value unchanged.
- R5: With `mode_i` = 3'b010 (toward minus infinity), a non-zero fraction raises the magnitude of a negative value by one and leaves the magnitude of a positive value unchanged.
- R6: When `sign_i` is 1, the result is the two's-complement negation of the rounded magnitude. A negative input that rounds to zero gives 0.
- R7: `invalid_o` is raised when the result does not fit in 32-bit signed range. That is a rounded magnitude above 0x7FFFFFFF for a positive input, or above 0x80000000 for a negative one. In that case `res_o` is 0x7FFFFFFF for a positive input and 0x80000000 for a negative one.
- R8: `inexact_o` is 1 exactly when the fraction bits are non-zero and `invalid_o` is 0. The two flags are never both 1.
- R9: The unused mode codes 3'b101, 3'b110 and 3'b111 behave exactly as toward zero, flags included.
- R10: In the registered build, outputs reflect the inputs of the previous rising edge, with results back to back on every cycle. A synchronous reset with `rst_n` low clears `res_o`, `invalid_o` and `inexact_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sign_i | input | 1 | 1 when the value is negative |
| mag_i | input | 64 | Unsigned magnitude, 7 fraction bits, top bit must be 0 |
| mode_i | input | 3 | Rounding direction code |
| res_o | output | 32 | Rounded, saturated signed integer |
| invalid_o | output | 1 | Result out of range, output saturated |
| inexact_o | output | 1 | Fraction was non-zero and result in range |

## Verification
The bench targets exact halves in both nearest modes, with odd and even integer parts. A design that confused the two tie rules, or applied the even-forcing outside nearest-even, would be off by one there. It drives the asymmetric edge of the signed range: a negative magnitude of exactly 2^31 must pass while the positive one saturates. Off-by-one range checks, or a sign test made before negation, show up as wrong saturation. It also covers values that round up across that edge, negative inputs that round to zero, directed modes with each sign (a swapped sign test moves the result by one), and the unused mode codes, which an incomplete decode would round as something else.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic [2:0] {
        RND_NEAR_EVEN = 3'b000,
        RND_ZERO      = 3'b001,
        RND_DOWN      = 3'b010,
        RND_UP        = 3'b011,
        RND_NEAR_AWAY = 3'b100
    } rnd_mode_e;

endpackage

// File: rtl/fxr_incr.sv
// Chooses the constant added to the fraction field, and flags ties that
// must be pushed to an even result.
module fxr_incr #(
    parameter int FRAC_W = 7
) (
    input  logic [2:0]        mode_i,
    input  logic              sign_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] inc_o,
    output logic              clr_lsb_o
);
    import fxr_pkg::*;

    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);
    localparam logic [FRAC_W-1:0] ALL1 = {FRAC_W{1'b1}};

    always_comb begin
        inc_o     = '0;
        clr_lsb_o = 1'b0;
        case (mode_i)
            RND_NEAR_EVEN: begin
                inc_o     = HALF;
                clr_lsb_o = (frac_i == HALF);
            end
            RND_NEAR_AWAY: inc_o = HALF;
            RND_UP:        inc_o = sign_i ? '0 : ALL1;
            RND_DOWN:      inc_o = sign_i ? ALL1 : '0;
            default:       inc_o = '0;
        endcase
    end
endmodule

// File: rtl/fxr_pack.sv
// Applies the sign to the rounded magnitude and saturates on overflow.
module fxr_pack #(
    parameter int SH_W  = 58,
    parameter int OUT_W = 32
) (
    input  logic             sign_i,
    input  logic [SH_W-1:0]  mag_i,
    output logic [OUT_W-1:0] value_o,
    output logic             ovf_o
);
    localparam logic [OUT_W-1:0] SAT_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] SAT_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] low;
    logic [OUT_W-1:0] signed_val;
    logic             high_set;

    always_comb begin
        low        = mag_i[OUT_W-1:0];
        signed_val = sign_i ? (~low + OUT_W'(1)) : low;
        high_set   = |mag_i[SH_W-1:OUT_W];
        ovf_o      = high_set || ((signed_val != '0) && (signed_val[OUT_W-1] != sign_i));
        value_o    = ovf_o ? (sign_i ? SAT_NEG : SAT_POS) : signed_val;
    end
endmodule

// File: rtl/fx_round_int.sv
module fx_round_int #(
    parameter int IN_W    = 64,
    parameter int FRAC_W  = 7,
    parameter int OUT_W   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sign_i,
    input  logic [IN_W-1:0]  mag_i,
    input  logic [2:0]       mode_i,
    output logic [OUT_W-1:0] res_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    localparam int SUM_W = IN_W + 1;
    localparam int SH_W  = SUM_W - FRAC_W;

    typedef struct packed {
        logic [OUT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } res_t;

    logic [FRAC_W-1:0] inc;
    logic              clr_lsb;
    logic [SUM_W-1:0]  sum;
    logic [SH_W-1:0]   rounded;
    logic [OUT_W-1:0]  packed_val;
    logic              ovf;
    res_t              res_d;
    res_t              res_q;

    fxr_incr #(.FRAC_W(FRAC_W)) u_incr (
        .mode_i    (mode_i),
        .sign_i    (sign_i),
        .frac_i    (mag_i[FRAC_W-1:0]),
        .inc_o     (inc),
        .clr_lsb_o (clr_lsb)
    );

    always_comb begin
        sum     = {1'b0, mag_i} + {{(SUM_W-FRAC_W){1'b0}}, inc};
        rounded = sum[SUM_W-1:FRAC_W] & ~{{(SH_W-1){1'b0}}, clr_lsb};
    end

    fxr_pack #(.SH_W(SH_W), .OUT_W(OUT_W)) u_pack (
        .sign_i  (sign_i),
        .mag_i   (rounded),
        .value_o (packed_val),
        .ovf_o   (ovf)
    );

    always_comb begin
        res_d.value   = packed_val;
        res_d.invalid = ovf;
        res_d.inexact = !ovf && (mag_i[FRAC_W-1:0] != '0);
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign res_o     = res_q.value;
    assign invalid_o = res_q.invalid;
    assign inexact_o = res_q.inexact;
endmodule

// File: rtl/fx_round_int_chk.sv
module fx_round_int_chk #(
    parameter int IN_W    = 64,
    parameter int FRAC_W  = 7,
    parameter int OUT_W   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sign_i,
    input logic [IN_W-1:0]  mag_i,
    input logic [OUT_W-1:0] res_o,
    input logic             invalid_o,
    input logic             inexact_o
);
    localparam logic [OUT_W-1:0] SAT_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] SAT_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid_o && inexact_o));

    // R7
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (res_o == SAT_POS || res_o == SAT_NEG));

    generate
        if (OUT_REG) begin : g_seq
            // R10
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (res_o == '0 && !invalid_o && !inexact_o));

            // R7
            sat_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
                invalid_o |-> (res_o[OUT_W-1] == $past(sign_i)));

            // R6
            result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!invalid_o && res_o != '0) |-> (res_o[OUT_W-1] == $past(sign_i)));

            // R8
            inexact_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
                inexact_o |-> ($past(mag_i[FRAC_W-1:0]) != '0));
        end
    endgenerate
endmodule

bind fx_round_int fx_round_int_chk #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sign_i    (sign_i),
    .mag_i     (mag_i),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
);

// File: tb/fx_round_int_tb.sv
module fx_round_int_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sign_i = 1'b0;
    logic [63:0] mag_i = '0;
    logic [2:0]  mode_i = '0;
    logic [31:0] res_o;
    logic        invalid_o;
    logic        inexact_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        logic [31:0] v;
        bit          inv;
        bit          inx;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    fx_round_int u_dut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .mag_i(mag_i),
        .mode_i(mode_i), .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
    );

    function automatic logic [63:0] mk(input logic [63:0] ip, input int fr);
        return (ip << 7) | 64'(fr & 8'h7F);
    endfunction

    function automatic exp_t model(input bit s, input logic [63:0] m,
                                   input logic [2:0] md, input string tag);
        exp_t e;
        logic [63:0] q = m >> 7;
        logic [6:0]  r = m[6:0];
        bit up;
        case (md)
            3'b000:  up = (r > 7'h40) || (r == 7'h40 && q[0]);
            3'b100:  up = (r >= 7'h40);
            3'b011:  up = !s && (r != 0);
            3'b010:  up = s && (r != 0);
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        e.inv = s ? (q > 64'h8000_0000) : (q > 64'h7FFF_FFFF);
        e.v   = e.inv ? (s ? 32'h8000_0000 : 32'h7FFF_FFFF)
                      : (s ? (32'd0 - q[31:0]) : q[31:0]);
        e.inx = !e.inv && (r != 0);
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input bit s, input logic [63:0] m,
                         input logic [2:0] md, input string tag);
        @(negedge clk);
        sign_i = s;
        mag_i  = m;
        mode_i = md;
        sb.push_back(model(s, m, md, tag));
    endtask

    // monitor: one registered result per driven cycle
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (res_o !== e.v || invalid_o !== e.inv || inexact_o !== e.inx) begin
                n_fail++;
                $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
                         e.tag, res_o, invalid_o, inexact_o, e.v, e.inv, e.inx);
            end
        end
    end

    task automatic check_reset(input string tag);
        n_tests++;
        if (res_o !== 32'h0 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=0 inv=0 inx=0",
                     tag, res_o, invalid_o, inexact_o);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check_reset("R10");
        @(negedge clk) rst_n = 1'b1;

        // R1 toward zero
        drive(0, mk(5, 7'h7F), 3'b001, "R1");
        drive(0, mk(100, 0),   3'b001, "R1");
        // R2 nearest even
        drive(0, mk(2, 7'h40), 3'b000, "R2");
        drive(0, mk(3, 7'h40), 3'b000, "R2");
        drive(0, mk(2, 7'h41), 3'b000, "R2");
        drive(0, mk(2, 7'h3F), 3'b000, "R2");
        drive(1, mk(5, 7'h40), 3'b000, "R2");
        // R3 ties away
        drive(0, mk(2, 7'h40), 3'b100, "R3");
        drive(1, mk(2, 7'h40), 3'b100, "R3");
        drive(0, mk(2, 7'h3F), 3'b100, "R3");
        // R4 toward plus infinity
        drive(0, mk(2, 1), 3'b011, "R4");
        drive(1, mk(2, 1), 3'b011, "R4");
        drive(0, mk(9, 0), 3'b011, "R4");
        // R5 toward minus infinity
        drive(0, mk(2, 7'h7F), 3'b010, "R5");
        drive(1, mk(2, 1),     3'b010, "R5");
        // R6 negation and negative zero
        drive(1, mk(7, 0),     3'b001, "R6");
        drive(1, mk(0, 7'h20), 3'b000, "R6");
        // R7 range edges and saturation
        drive(0, mk(64'h8000_0000, 0),    3'b001, "R7");
        drive(1, mk(64'h8000_0000, 0),    3'b001, "R7");
        drive(1, mk(64'h8000_0001, 0),    3'b001, "R7");
        drive(0, mk(64'h7FFF_FFFF, 7'h7F), 3'b011, "R7");
        drive(0, mk(64'h7FFF_FFFF, 7'h40), 3'b000, "R7");
        drive(1, mk(64'h8000_0000, 7'h01), 3'b010, "R7");
        drive(0, mk(64'h1_0000_0000, 5),  3'b001, "R7");
        drive(1, 64'h7FFF_FFFF_FFFF_FFFF, 3'b011, "R7");
        // R8 inexact rules
        drive(0, mk(11, 7'h01), 3'b000, "R8");
        drive(1, mk(11, 0),     3'b010, "R8");
        // R9 unused mode codes
        drive(1, mk(2, 7'h7F), 3'b101, "R9");
        drive(0, mk(2, 7'h7F), 3'b110, "R9");
        drive(1, mk(2, 7'h40), 3'b111, "R9");
        // R10 back to back then reset
        drive(0, mk(40, 0), 3'b001, "R10");
        drive(1, mk(41, 0), 3'b001, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check_reset("R10");
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule